// File: doc/BRIEF.md
# Tone Pair Period Classifier

This block receives two clean square waves, one from the low tone band and one from the high tone band. Both are already band-split and hard-limited upstream. For each band it counts master clock cycles across four consecutive rising-edge periods. It then matches that total against four tolerance windows, one for each nominal frequency of the band. A band is declared good only when two back-to-back totals fall into the same window.

When both bands are good at the same time, the block raises `steer` and presents a 4-bit key code on `digit_code`. The code is taken from the row (low band) and column (high band) pair. `steer` falls as soon as either band produces a total that misses every window, or goes silent for longer than its slowest window allows.

There is no stream handshake. `digit_code` is a level qualified by `steer`. A consumer samples it while `steer` is high and cannot apply back-pressure. The code register holds its last value while `steer` is low.

Top module: `tone_pair_classifier`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it, `steer` is 0 and `digit_code` is 0.
- R2: A tone within ±1.5% ±2 Hz of a nominal frequency is accepted. Low band: 697, 770, 852, 941 Hz, rows 0 to 3. High band: 1209, 1336, 1477, 1633 Hz, columns 0 to 3. The window is ±2.5% of the frequency, taken as a total of `NPER` periods at `CLK_HZ`.
- R3: A tone deviating by 3.5% or more from every nominal frequency of its band is rejected, and `steer` stays 0.
- R4: A band becomes good only after two consecutive four-period totals land in the same window, so a single total never raises `steer`.
- R5: A total in either band that misses every window (or lands in a different window) lowers `steer` two cycles after the measurement completes.
- R6: If a band sees no rising edge for longer than the upper limit of its slowest window, that band's measurement fails and `steer` falls.
- R7: Code map, with the row first then the column. Rows 0 to 2 with columns 0 to 2 give 3·row+col+1 (1 to 9). Row 3 gives 11 with column 0, 10 with column 1 and 12 with column 2. Column 3 gives 13, 14, 15 and 0 for rows 0 to 3.
- R8: While `steer` stays high, `digit_code` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, nominal rate `CLK_HZ` |
| rst_n | input | 1 | Active-low synchronous reset |
| low_wave | input | 1 | Limited low-band square wave, asynchronous |
| high_wave | input | 1 | Limited high-band square wave, asynchronous |
| steer | output | 1 | High while both bands hold a qualified frequency |
| digit_code | output | 4 | Key code of the qualified row/column pair |

## Verification
Two things can fall into one cycle: a passing measurement in one band and a failing measurement in the other. The drop must win, and `steer` must not be held up by the passing band. The bench provokes this by keeping the high band at a valid frequency while moving the low band 5% off nominal under a live key. Its measurements then keep completing in between those of the high band. The check is that `steer` ends low and stays low while the high band keeps passing. The overflow case is judged the same way, by silencing one band under a live key.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  // Lower bound (inclusive) of the window in clock cycles: f at +2.5%.
  function automatic int unsigned win_lo(longint unsigned clk_hz,
                                         longint unsigned nper,
                                         longint unsigned f_hz);
    longint unsigned num;
    longint unsigned den;
    num = clk_hz * nper * 40;
    den = f_hz * 41;
    return int'((num + den - 1) / den);
  endfunction

  // Upper bound (inclusive) of the window in clock cycles: f at -2.5%.
  function automatic int unsigned win_hi(longint unsigned clk_hz,
                                         longint unsigned nper,
                                         longint unsigned f_hz);
    return int'((clk_hz * nper * 40) / (f_hz * 39));
  endfunction

  // Row/column to key code.
  function automatic logic [3:0] key_code(logic [1:0] row, logic [1:0] col);
    logic [3:0] r4;
    logic [3:0] c4;
    r4 = {2'b00, row};
    c4 = {2'b00, col};
    if (col == 2'd3)      return 4'd13 + r4;
    else if (row == 2'd3) return (col == 2'd0) ? 4'd11 : (col == 2'd1) ? 4'd10 : 4'd12;
    else                  return (r4 * 4'd3) + c4 + 4'd1;
  endfunction

endpackage

// File: rtl/tpc_period_meas.sv
module tpc_period_meas #(
  parameter int unsigned CLK_HZ  = 3579000,
  parameter int unsigned NPER    = 4,
  parameter int unsigned FREQ[4] = '{697, 770, 852, 941}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wave,
  output logic       m_stb,
  output logic       m_ok,
  output logic [1:0] m_idx
);
  localparam int unsigned LIMIT = tpc_pkg::win_hi(CLK_HZ, NPER, FREQ[0]);
  localparam int unsigned CW    = $clog2(LIMIT + 1) + 1;
  localparam int unsigned EW    = (NPER > 2) ? $clog2(NPER) : 1;

  logic          sync1, sync2, sync3;
  logic          rise;
  logic          armed;
  logic [CW-1:0] cnt;
  logic [EW-1:0] edges;
  int unsigned   total;
  logic [3:0]    hit;
  logic [1:0]    hit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) {sync1, sync2, sync3} <= 3'b000;
    else        {sync1, sync2, sync3} <= {wave, sync1, sync2};
  end
  assign rise  = sync2 & ~sync3;
  assign total = 32'(cnt) + 32'd1;

  for (genvar g = 0; g < 4; g++) begin : g_win
    localparam int unsigned LO = tpc_pkg::win_lo(CLK_HZ, NPER, FREQ[g]);
    localparam int unsigned HI = tpc_pkg::win_hi(CLK_HZ, NPER, FREQ[g]);
    assign hit[g] = (total >= LO) && (total <= HI);
  end

  always_comb begin
    hit_idx = 2'd0;
    for (int i = 0; i < 4; i++) if (hit[i]) hit_idx = 2'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      edges <= '0;
      m_stb <= 1'b0;
      m_ok  <= 1'b0;
      m_idx <= 2'd0;
    end else begin
      m_stb <= 1'b0;
      if (!armed) begin
        if (rise) begin
          armed <= 1'b1;
          cnt   <= '0;
          edges <= '0;
        end
      end else if (rise) begin
        if (edges == EW'(NPER - 1)) begin
          m_stb <= 1'b1;
          m_ok  <= |hit;
          m_idx <= hit_idx;
          cnt   <= '0;
          edges <= '0;
        end else begin
          edges <= edges + 1'b1;
          cnt   <= cnt + 1'b1;
        end
      end else if (cnt == CW'(LIMIT)) begin
        m_stb <= 1'b1;
        m_ok  <= 1'b0;
        armed <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tpc_qualify.sv
module tpc_qualify (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       m_stb,
  input  logic       m_ok,
  input  logic [1:0] m_idx,
  output logic       good,
  output logic [1:0] good_idx
);
  logic       prev_ok;
  logic [1:0] prev_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ok  <= 1'b0;
      prev_idx <= 2'd0;
      good     <= 1'b0;
      good_idx <= 2'd0;
    end else if (m_stb) begin
      good     <= m_ok && prev_ok && (m_idx == prev_idx);
      good_idx <= m_idx;
      prev_ok  <= m_ok;
      prev_idx <= m_idx;
    end
  end
endmodule

// File: rtl/tone_pair_classifier.sv
module tone_pair_classifier #(
  parameter int unsigned CLK_HZ    = 3579000,
  parameter int unsigned NPER      = 4,
  parameter int unsigned LOW_F[4]  = '{697, 770, 852, 941},
  parameter int unsigned HIGH_F[4] = '{1209, 1336, 1477, 1633}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       low_wave,
  input  logic       high_wave,
  output logic       steer,
  output logic [3:0] digit_code
);
  logic       lo_stb, lo_ok, lo_good;
  logic [1:0] lo_idx, lo_row;
  logic       hi_stb, hi_ok, hi_good;
  logic [1:0] hi_idx, hi_col;

  tpc_period_meas #(.CLK_HZ(CLK_HZ), .NPER(NPER), .FREQ(LOW_F)) u_lo_meas (
    .clk(clk), .rst_n(rst_n), .wave(low_wave),
    .m_stb(lo_stb), .m_ok(lo_ok), .m_idx(lo_idx));

  tpc_period_meas #(.CLK_HZ(CLK_HZ), .NPER(NPER), .FREQ(HIGH_F)) u_hi_meas (
    .clk(clk), .rst_n(rst_n), .wave(high_wave),
    .m_stb(hi_stb), .m_ok(hi_ok), .m_idx(hi_idx));

  tpc_qualify u_lo_qual (
    .clk(clk), .rst_n(rst_n), .m_stb(lo_stb), .m_ok(lo_ok), .m_idx(lo_idx),
    .good(lo_good), .good_idx(lo_row));

  tpc_qualify u_hi_qual (
    .clk(clk), .rst_n(rst_n), .m_stb(hi_stb), .m_ok(hi_ok), .m_idx(hi_idx),
    .good(hi_good), .good_idx(hi_col));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      steer      <= 1'b0;
      digit_code <= 4'd0;
    end else begin
      steer <= lo_good & hi_good;
      if (lo_good & hi_good) digit_code <= tpc_pkg::key_code(lo_row, hi_col);
    end
  end
endmodule

// File: rtl/tpc_sva.sv
module tpc_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       steer,
  input logic [3:0] code,
  input logic       lo_stb,
  input logic       lo_ok,
  input logic       lo_good,
  input logic       hi_stb,
  input logic       hi_ok,
  input logic       hi_good
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!steer && code == 4'd0));

  assert_lo_qualify_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_good) |-> $past(lo_stb && lo_ok));

  assert_hi_qualify_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_good) |-> $past(hi_stb && hi_ok));

  assert_lo_fail_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_stb && !lo_ok) |=> ##1 !steer);

  assert_hi_fail_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_stb && !hi_ok) |=> ##1 !steer);

  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (steer && $past(steer)) |-> $stable(code));
endmodule

bind tone_pair_classifier tpc_sva u_sva (
  .clk(clk), .rst_n(rst_n), .steer(steer), .code(digit_code),
  .lo_stb(lo_stb), .lo_ok(lo_ok), .lo_good(lo_good),
  .hi_stb(hi_stb), .hi_ok(hi_ok), .hi_good(hi_good));

// File: tb/tone_pair_classifier_tb.sv
`timescale 1ns/1ps
module tone_pair_classifier_tb;
  localparam int unsigned SIM_HZ = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       low_wave = 1'b0;
  logic       high_wave = 1'b0;
  logic       steer;
  logic [3:0] digit_code;

  int lo_per = 0;
  int hi_per = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tone_pair_classifier #(.CLK_HZ(SIM_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .low_wave(low_wave), .high_wave(high_wave),
    .steer(steer), .digit_code(digit_code));

  initial forever begin
    int p;
    p = lo_per;
    if (p == 0) begin low_wave = 1'b0; @(negedge clk); end
    else begin
      low_wave = 1'b1; repeat (p / 2) @(negedge clk);
      low_wave = 1'b0; repeat (p - p / 2) @(negedge clk);
    end
  end

  initial forever begin
    int p;
    p = hi_per;
    if (p == 0) begin high_wave = 1'b0; @(negedge clk); end
    else begin
      high_wave = 1'b1; repeat (p / 2) @(negedge clk);
      high_wave = 1'b0; repeat (p - p / 2) @(negedge clk);
    end
  end

  function automatic int per_of(real f);
    return $rtoi(real'(SIM_HZ) / f + 0.5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic silence();
    lo_per = 0; hi_per = 0;
    wait_cyc(1500);
  endtask

  task automatic t_reset();
    wait_cyc(3);
    check(steer == 1'b0, "R1 steer in reset", steer, 0);
    check(digit_code == 4'd0, "R1 code in reset", digit_code, 0);
    rst_n = 1'b1;
    wait_cyc(1);
    check(steer == 1'b0, "R1 steer after reset", steer, 0);
  endtask

  task automatic t_key(input real fl, input real fh, input int exp, input string req);
    silence();
    lo_per = per_of(fl); hi_per = per_of(fh);
    wait_cyc(1800);
    check(steer == 1'b1, req, steer, 1);
    check(digit_code == 4'(exp), req, digit_code, exp);
  endtask

  task automatic t_single_meas();
    silence();
    lo_per = per_of(697.0); hi_per = per_of(1209.0);
    wait_cyc(800);
    check(steer == 1'b0, "R4 one low total only", steer, 0);
    wait_cyc(1000);
    check(steer == 1'b1, "R4 after two totals", steer, 1);
  endtask

  task automatic t_reject(input real fl, input real fh);
    silence();
    lo_per = per_of(fl); hi_per = per_of(fh);
    wait_cyc(2500);
    check(steer == 1'b0, "R3 off-tolerance rejected", steer, 0);
  endtask

  task automatic t_drop_mixed();
    t_key(697.0, 1209.0, 1, "R7 key 1 before drop");
    lo_per = per_of(697.0 * 1.05);
    wait_cyc(1500);
    check(steer == 1'b0, "R5 low fails while high passes", steer, 0);
    wait_cyc(1000);
    check(steer == 1'b0, "R5 stays low", steer, 0);
  endtask

  task automatic t_overflow();
    t_key(852.0, 1477.0, 9, "R7 key 9 before overflow");
    hi_per = 0;
    wait_cyc(600);
    check(steer == 1'b0, "R6 high band silent", steer, 0);
  endtask

  task automatic t_hold();
    bit same;
    t_key(770.0, 1336.0, 5, "R7 key 5");
    same = 1'b1;
    for (int i = 0; i < 50; i++) begin
      wait_cyc(20);
      if (digit_code != 4'd5 || !steer) same = 1'b0;
    end
    check(same, "R8 code held under steer", digit_code, 5);
  endtask

  initial begin
    t_reset();
    t_key(697.0, 1209.0, 1, "R7 key 1");
    t_key(941.0, 1336.0, 10, "R7 key 0 -> 10");
    t_key(941.0, 1209.0, 11, "R7 key star -> 11");
    t_key(941.0, 1477.0, 12, "R7 key hash -> 12");
    t_key(697.0, 1633.0, 13, "R7 key A -> 13");
    t_key(941.0, 1633.0, 0, "R7 key D -> 0");
    t_single_meas();
    t_key(697.0 * 1.015 + 2.0, 1633.0 * 1.015 + 2.0, 13, "R2 +1.5%+2Hz");
    t_key(697.0 * 0.985 - 2.0, 1633.0 * 0.985 - 2.0, 13, "R2 -1.5%-2Hz");
    t_key(852.0 * 1.015 + 2.0, 1336.0 * 0.985 - 2.0, 8, "R2 mixed deviation");
    t_reject(697.0 * 1.035, 1209.0);
    t_reject(697.0 * 0.965, 1209.0);
    t_reject(852.0, 1633.0 * 1.035);
    t_reject(852.0, 1633.0 * 0.965);
    t_drop_mixed();
    t_overflow();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule